// File: doc/BRIEF.md
# Narrow-Bus Port to Wide FIFOs

This block places two 32-bit FIFOs behind a 16-bit host register bus. On the outbound side, the host drains a measurement FIFO. It reads each 32-bit entry as two 16-bit halves, and the entry leaves the FIFO only once its second half has been read. On the inbound side, the host fills a source FIFO. It writes two 16-bit halves, and the block pushes the assembled 32-bit word when the second half arrives.

A count register tells the host how many 16-bit transfers it may make. The `count_dir` input selects which FIFO the count describes: the words waiting on the outbound side, or the free room on the inbound side. The count is derived from the FIFO levels at the moment of the read, less any half-word already moved. It saturates at 65535. The FIFOs may fill or drain on their far sides while the host works, so the count can lag behind the true amount but is never larger than it.

The FIFO memories are outside the block. The outbound FIFO shows its head word, an empty flag and an occupancy level. The inbound FIFO shows a full flag and a free-entry level. Both take single-cycle pop and push strobes.

Top module: `nbp_fifo_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `host_rdata` is 0 and neither `snd_pop` nor `rcv_push` is asserted. No half-word is pending on either side.
- R2: A read of address 0 returns bits 31:16 of the outbound head word. It does not pop the outbound FIFO.
- R3: A read of address 1 returns bits 15:0 of the outbound head word. It asserts `snd_pop` in the same cycle as the read strobe.
- R4: A read of address 0 or 1 while `snd_empty` is high returns 0 and does not pop. It leaves no half-word pending.
- R5: A write to address 2 holds its data as the upper half. A later write to address 3 while `rcv_full` is low asserts `rcv_push` in that same cycle, with `rcv_word` = {held upper half, write data}.
- R6: A write to address 3 while `rcv_full` is high does not push and does not change the held upper half or the pending state. A later write to address 3 pushes with the same upper half.
- R7: A read of address 4 with `count_dir` = 0 returns 2·`snd_level`, minus 1 if the upper half of the head word has been read and the lower half has not.
- R8: A read of address 4 with `count_dir` = 1 returns 2·`rcv_free`, minus 1 if an upper half is held and not yet pushed. The result is floored at 0.
- R9: Any count value above 65535 is reported as 65535.
- R10: Read data appears on `host_rdata` in the cycle after the read strobe. It is 0 in every cycle that does not follow a read.
- R11: Reads of addresses 2, 3 and 5 to 7 return 0. Writes to addresses 0, 1 and 4 neither pop, push nor change pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register select (0/1 outbound upper/lower, 2/3 inbound upper/lower, 4 count) |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data, valid the cycle after `host_rd` |
| count_dir | input | 1 | Count source: 0 outbound occupancy, 1 inbound free room |
| snd_empty | input | 1 | Outbound FIFO empty |
| snd_word | input | 32 | Outbound FIFO head word (show-ahead) |
| snd_level | input | LVL_W | Outbound FIFO occupancy in 32-bit words |
| snd_pop | output | 1 | Outbound FIFO pop strobe |
| rcv_full | input | 1 | Inbound FIFO full |
| rcv_free | input | LVL_W | Inbound FIFO free entries in 32-bit words |
| rcv_push | output | 1 | Inbound FIFO push strobe |
| rcv_word | output | 32 | Inbound FIFO push data |

## Verification
The properties assume the host never raises `host_rd` and `host_wr` in the same cycle. They also assume the outbound FIFO keeps its head word steady between pops, and that `snd_level` is nonzero whenever `snd_empty` is low. The stimulus drives one strobe at a time and holds the FIFO-side inputs fixed across each pair of half accesses. It changes those inputs only in an idle cycle, after the last read has been captured. The bench stands in for the FIFOs by setting empty, full, level and head-word values directly. It updates them by hand after each pop or push, so the expected counts follow from the requirements alone.

// File: rtl/nbp_fifo_port_pkg.sv
package nbp_fifo_port_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;
   localparam int SEL_W  = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_SND_HI = 3'd0,
      SEL_SND_LO = 3'd1,
      SEL_RCV_HI = 3'd2,
      SEL_RCV_LO = 3'd3,
      SEL_COUNT  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/nbp_send_split.sv
module nbp_send_split
   import nbp_fifo_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_hi,
   input  logic              rd_lo,
   input  logic              empty,
   input  logic [WORD_W-1:0] word,
   output logic [HALF_W-1:0] half,
   output logic              pop,
   output logic              hi_pend
);
   logic pend_q;

   // Only a lower-half read of a present word retires it
   assign pop  = rd_lo && !empty;
   assign half = empty ? '0 : (rd_lo ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (pop)
         pend_q <= 1'b0;
      else if (rd_hi && !empty)
         pend_q <= 1'b1;
   end

   assign hi_pend = pend_q;
endmodule

// File: rtl/nbp_recv_join.sv
module nbp_recv_join
   import nbp_fifo_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [HALF_W-1:0] wdata,
   input  logic              full,
   output logic              push,
   output logic [WORD_W-1:0] word,
   output logic              hi_pend
);
   logic [HALF_W-1:0] hold_q;
   logic              pend_q;

   assign push = wr_lo && !full;
   assign word = {hold_q, wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         pend_q <= 1'b0;
      end else if (wr_hi) begin
         hold_q <= wdata;
         pend_q <= 1'b1;
      end else if (push) begin
         pend_q <= 1'b0;
      end
   end

   assign hi_pend = pend_q;
endmodule

// File: rtl/nbp_count_gen.sv
module nbp_count_gen
   import nbp_fifo_port_pkg::*;
#(
   parameter int LVL_W = 17
) (
   input  logic [LVL_W-1:0]  level,
   input  logic              pend,
   output logic [HALF_W-1:0] cnt
);
   localparam int DBL_W = LVL_W + 1;

   logic [DBL_W-1:0] dbl;
   logic [DBL_W-1:0] net;

   assign dbl = {level, 1'b0};
   // A pending half takes one unit; never go below zero
   assign net = (dbl == '0) ? '0 : (dbl - DBL_W'(pend));

   generate
      if (DBL_W > HALF_W) begin : g_sat
         assign cnt = (|net[DBL_W-1:HALF_W]) ? '1 : net[HALF_W-1:0];
      end else begin : g_fit
         assign cnt = HALF_W'(net);
      end
   endgenerate
endmodule

// File: rtl/nbp_fifo_port.sv
module nbp_fifo_port
   import nbp_fifo_port_pkg::*;
#(
   parameter int LVL_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [15:0]       host_wdata,
   output logic [15:0]       host_rdata,
   input  logic              count_dir,
   input  logic              snd_empty,
   input  logic [31:0]       snd_word,
   input  logic [LVL_W-1:0]  snd_level,
   output logic              snd_pop,
   input  logic              rcv_full,
   input  logic [LVL_W-1:0]  rcv_free,
   output logic              rcv_push,
   output logic [31:0]       rcv_word
);
   generate
      if (LVL_W < 1 || LVL_W > 24) begin : g_bad_lvl
         $error("nbp_fifo_port: LVL_W must lie in 1..24");
      end
      if (HALF_W != 16 || WORD_W != 32) begin : g_bad_w
         $error("nbp_fifo_port: port widths assume 16/32 bit halves/words");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(host_addr);

   logic              rd_hi, rd_lo, wr_hi, wr_lo;
   logic [HALF_W-1:0] snd_half;
   logic              snd_pend, rcv_pend;
   logic [HALF_W-1:0] snd_cnt, rcv_cnt;
   logic [HALF_W-1:0] rd_mux;
   logic [HALF_W-1:0] rdata_q;

   assign rd_hi = host_rd && (sel == SEL_SND_HI);
   assign rd_lo = host_rd && (sel == SEL_SND_LO);
   assign wr_hi = host_wr && (sel == SEL_RCV_HI);
   assign wr_lo = host_wr && (sel == SEL_RCV_LO);

   nbp_send_split u_split (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_hi   (rd_hi),
      .rd_lo   (rd_lo),
      .empty   (snd_empty),
      .word    (snd_word),
      .half    (snd_half),
      .pop     (snd_pop),
      .hi_pend (snd_pend)
   );

   nbp_recv_join u_join (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wdata   (host_wdata),
      .full    (rcv_full),
      .push    (rcv_push),
      .word    (rcv_word),
      .hi_pend (rcv_pend)
   );

   nbp_count_gen #(.LVL_W(LVL_W)) u_snd_cnt (
      .level (snd_level),
      .pend  (snd_pend),
      .cnt   (snd_cnt)
   );

   nbp_count_gen #(.LVL_W(LVL_W)) u_rcv_cnt (
      .level (rcv_free),
      .pend  (rcv_pend),
      .cnt   (rcv_cnt)
   );

   always_comb begin
      case (sel)
         SEL_SND_HI, SEL_SND_LO: rd_mux = snd_half;
         SEL_COUNT:              rd_mux = count_dir ? rcv_cnt : snd_cnt;
         default:                rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (host_rd)
         rdata_q <= rd_mux;
      else
         rdata_q <= '0;
   end

   assign host_rdata = rdata_q;
endmodule

// File: rtl/nbp_fifo_port_chk.sv
module nbp_fifo_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  host_addr,
   input logic        host_rd,
   input logic        host_wr,
   input logic [15:0] host_wdata,
   input logic [15:0] host_rdata,
   input logic        snd_empty,
   input logic        snd_pop,
   input logic        rcv_full,
   input logic        rcv_push,
   input logic [31:0] rcv_word
);
   p_no_pop_on_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 3'd0) |-> !snd_pop);

   p_pop_needs_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      snd_pop |-> (host_rd && host_addr == 3'd1));

   p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      snd_empty |-> !snd_pop);

   p_push_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_push |-> (host_wr && host_addr == 3'd3 && rcv_word[15:0] == host_wdata));

   p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rcv_full |-> !rcv_push);

   p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> (host_rdata == 16'h0000));

   p_write_no_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |-> !snd_pop);
endmodule

bind nbp_fifo_port nbp_fifo_port_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_addr  (host_addr),
   .host_rd    (host_rd),
   .host_wr    (host_wr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .snd_empty  (snd_empty),
   .snd_pop    (snd_pop),
   .rcv_full   (rcv_full),
   .rcv_push   (rcv_push),
   .rcv_word   (rcv_word)
);

// File: tb/sim_nbp_fifo_port.sv
`timescale 1ns/1ps
module sim_nbp_fifo_port;
   localparam int LVL_W = 17;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2:0]       host_addr = '0;
   logic             host_rd = 1'b0;
   logic             host_wr = 1'b0;
   logic [15:0]      host_wdata = '0;
   logic [15:0]      host_rdata;
   logic             count_dir = 1'b0;
   logic             snd_empty = 1'b1;
   logic [31:0]      snd_word = '0;
   logic [LVL_W-1:0] snd_level = '0;
   logic             snd_pop;
   logic             rcv_full = 1'b0;
   logic [LVL_W-1:0] rcv_free = '0;
   logic             rcv_push;
   logic [31:0]      rcv_word;

   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   nbp_fifo_port #(.LVL_W(LVL_W)) u0 (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .count_dir(count_dir), .snd_empty(snd_empty), .snd_word(snd_word),
      .snd_level(snd_level), .snd_pop(snd_pop), .rcv_full(rcv_full),
      .rcv_free(rcv_free), .rcv_push(rcv_push), .rcv_word(rcv_word)
   );

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: issue a read, queue its expected data, check the pop strobe
   task automatic rd_reg(logic [2:0] a, logic [15:0] e, bit e_pop, string tag);
      @(negedge clk);
      host_rd = 1'b1; host_wr = 1'b0; host_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #1 chk(snd_pop == e_pop, {tag, " pop"}, 32'(snd_pop), 32'(e_pop));
   endtask

   task automatic wr_reg(logic [2:0] a, logic [15:0] d, bit e_push,
                         logic [31:0] e_word, string tag);
      @(negedge clk);
      host_rd = 1'b0; host_wr = 1'b1; host_addr = a; host_wdata = d;
      #1;
      chk(rcv_push == e_push, {tag, " push"}, 32'(rcv_push), 32'(e_push));
      chk(snd_pop == 1'b0, {tag, " pop"}, 32'(snd_pop), 32'd0);
      if (e_push)
         chk(rcv_word == e_word, {tag, " word"}, rcv_word, e_word);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         host_rd = 1'b0; host_wr = 1'b0;
      end
   endtask

   // Monitor: compare registered read data one cycle after each strobe
   initial begin
      bit          was_rd;
      logic [15:0] e;
      string       t;
      forever begin
         @(posedge clk);
         was_rd = host_rd && rst_n;
         @(negedge clk);
         if (was_rd) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10 unexpected read data", 32'(host_rdata), 32'd0);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(host_rdata == e, t, 32'(host_rdata), 32'(e));
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(host_rdata == 16'h0, "R1 rdata in reset", 32'(host_rdata), 32'd0);
      chk(!snd_pop && !rcv_push, "R1 strobes in reset", {snd_pop, rcv_push}, 32'd0);
      rst_n = 1'b1;
      idle(1);
      chk(host_rdata == 16'h0, "R1 rdata after reset", 32'(host_rdata), 32'd0);

      // Outbound split
      snd_empty = 1'b0; snd_word = 32'hA5A5_1234; snd_level = 17'd3; count_dir = 1'b0;
      rd_reg(3'd4, 16'd6, 1'b0, "R1 R7 count no pending");
      rd_reg(3'd0, 16'hA5A5, 1'b0, "R2 upper half");
      rd_reg(3'd4, 16'd5, 1'b0, "R7 count with pending half");
      rd_reg(3'd1, 16'h1234, 1'b1, "R3 lower half pops");
      rd_reg(3'd4, 16'd6, 1'b0, "R7 count after pop");
      idle(1);
      snd_word = 32'hDEAD_BEEF; snd_level = 17'd2;
      rd_reg(3'd0, 16'hDEAD, 1'b0, "R2 second upper");
      rd_reg(3'd1, 16'hBEEF, 1'b1, "R3 second lower");
      rd_reg(3'd4, 16'd4, 1'b0, "R7 count level 2");

      // Empty outbound
      idle(1);
      snd_empty = 1'b1; snd_level = '0; snd_word = 32'h7777_8888;
      rd_reg(3'd0, 16'h0, 1'b0, "R4 empty upper");
      rd_reg(3'd1, 16'h0, 1'b0, "R4 empty lower");
      rd_reg(3'd4, 16'd0, 1'b0, "R4 no pending after empty read");

      // Inbound join
      idle(1);
      count_dir = 1'b1; rcv_full = 1'b0; rcv_free = 17'd5;
      rd_reg(3'd4, 16'd10, 1'b0, "R8 free count");
      wr_reg(3'd2, 16'h1111, 1'b0, '0, "R5 upper write");
      rd_reg(3'd4, 16'd9, 1'b0, "R8 count with held half");
      wr_reg(3'd3, 16'h2222, 1'b1, 32'h1111_2222, "R5 lower write pushes");
      rd_reg(3'd4, 16'd10, 1'b0, "R8 count after push");

      // Full inbound
      idle(1);
      rcv_full = 1'b1; rcv_free = '0;
      wr_reg(3'd2, 16'h3333, 1'b0, '0, "R6 upper while full");
      rd_reg(3'd4, 16'd0, 1'b0, "R8 floor at zero");
      wr_reg(3'd3, 16'h4444, 1'b0, '0, "R6 lower while full dropped");
      idle(1);
      rcv_full = 1'b0; rcv_free = 17'd1;
      rd_reg(3'd4, 16'd1, 1'b0, "R6 half still pending");
      wr_reg(3'd3, 16'h5555, 1'b1, 32'h3333_5555, "R6 retry keeps upper");
      rd_reg(3'd4, 16'd2, 1'b0, "R8 count after retry");

      // Saturation
      idle(1);
      count_dir = 1'b0; snd_empty = 1'b0; snd_level = 17'd40000;
      rd_reg(3'd4, 16'hFFFF, 1'b0, "R9 send saturates");
      idle(1);
      snd_level = 17'd32768;
      rd_reg(3'd4, 16'hFFFF, 1'b0, "R9 exactly 65536");
      idle(1);
      snd_level = 17'd32767;
      rd_reg(3'd4, 16'hFFFE, 1'b0, "R9 just below limit");
      idle(1);
      count_dir = 1'b1; rcv_free = 17'd40000;
      rd_reg(3'd4, 16'hFFFF, 1'b0, "R9 receive saturates");

      // Ignored accesses
      idle(1);
      count_dir = 1'b0; snd_level = 17'd4; snd_word = 32'h0102_0304;
      wr_reg(3'd0, 16'h9999, 1'b0, '0, "R11 write to send upper");
      wr_reg(3'd1, 16'h9999, 1'b0, '0, "R11 write to send lower");
      wr_reg(3'd4, 16'h9999, 1'b0, '0, "R11 write to count");
      rd_reg(3'd4, 16'd8, 1'b0, "R11 no pending after writes");
      rd_reg(3'd2, 16'h0, 1'b0, "R11 read recv upper");
      rd_reg(3'd3, 16'h0, 1'b0, "R11 read recv lower");
      rd_reg(3'd6, 16'h0, 1'b0, "R11 read unused");
      idle(1);
      count_dir = 1'b1; rcv_free = 17'd3;
      rd_reg(3'd4, 16'd6, 1'b0, "R11 recv not pending after writes");
      idle(2);
      chk(host_rdata == 16'h0, "R10 idle rdata", 32'(host_rdata), 32'd0);
      idle(2);
      chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule